// File: doc/BRIEF.md
# Request/Ready Write Handshake Bus Slave

This block sits on the peripheral side of a shared parallel bus. It accepts byte writes from a bus master through a four-phase Request/Ready handshake. While the master holds Request high, the block compares the shared address lines with its own device address. On a match, with the write direction selected and room to take a byte, it raises Ready. Ready acknowledges the request and also marks the bus as held by this transfer.

The master then places a byte on the data lines and lowers Request. The block takes the byte from the lines in the first bus-clock sample where Request is low, stores it in a small internal queue, and only then lowers Ready to release the bus. If the storage side reports that it is busy, or the queue is full, Ready is held back and the master waits. A read request aimed at this device is refused with a one-cycle error pulse. A simple pop port lets the consumer take bytes out in arrival order.

Top module: `rrhs_slave`

## Requirements
- R1: While rst_n is low, and after it is released with no request, ready, err and pop_valid are all 0.
- R2: With req high, wr high (1 = write), addr equal to DEV_ADDR, store_busy low and the queue not full, ready goes high on the second rising clock edge after these inputs are first present.
- R3: When addr differs from DEV_ADDR, or req is low, ready stays 0 whatever the other lines carry.
- R4: Once high, ready stays high until req has been sampled low, even while data and address lines change.
- R5: The byte stored is the value on data at the first rising edge where req is sampled low after ready rose, and bytes leave the queue in the order they were written.
- R6: ready falls on the second rising edge after the edge where req is first sampled low, one edge after the byte enters the queue.
- R7: While the queue holds DEPTH bytes, a matching write request gets no ready and no byte is lost or overwritten; the request is granted once a pop frees a slot.
- R8: While store_busy is high, a matching write request gets no ready; the request is granted after store_busy falls.
- R9: A matching request with wr low (read) drives err high for exactly one cycle, on the second edge after the request appears, never raises ready, stores nothing, and gives no further err until req is lowered.
- R10: pop_valid is 1 whenever the queue is not empty, and pop_data shows the oldest byte. A pop with pop_valid high removes that byte at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| req | input | 1 | Request from the bus master |
| wr | input | 1 | Direction: 1 write, 0 read |
| addr | input | AW | Shared address lines |
| data | input | DW | Shared data lines |
| store_busy | input | 1 | Storage side cannot accept data now |
| ready | output | 1 | Handshake acknowledge and bus-held indication |
| err | output | 1 | One-cycle pulse refusing a read request |
| pop | input | 1 | Consumer removes the oldest byte |
| pop_data | output | DW | Oldest byte in the queue |
| pop_valid | output | 1 | Queue not empty |

## Verification
A handshake state machine left in the wrong state shows at ready within two edges. Ready either fails to rise after a matching request, or it stays high after Request has been sampled low. A capture taken one sample late or early, or a queue pointer out of step, appears as a mismatched or missing byte on pop_data at the next pop the scoreboard makes. A wrong full or busy decision shows as a grant while the queue is full, or as a stalled master after a pop frees a slot.

// File: rtl/rrhs_pkg.sv
package rrhs_pkg;

  // Handshake sequencer states
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,  // waiting for a matching request
    HS_GRANT = 2'd1,  // ready high, bus held, waiting for request to drop
    HS_STORE = 2'd2,  // captured byte is written into the queue
    HS_REFSE = 2'd3   // read refused, waiting for request to drop
  } hs_state_t;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/rrhs_sampler.sv
module rrhs_sampler #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          req_s,
  output logic          wr_s,
  output logic [AW-1:0] addr_s,
  output logic [DW-1:0] data_s,
  output logic          req_fall
);

  logic req_prev;

  // One bus-clock sample of every bus line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s    <= 1'b0;
      req_prev <= 1'b0;
      wr_s     <= 1'b0;
      addr_s   <= '0;
      data_s   <= '0;
    end else begin
      req_s    <= req;
      req_prev <= req_s;
      wr_s     <= wr;
      addr_s   <= addr;
      data_s   <= data;
    end
  end

  // Falling request: previous sample high, current sample low
  assign req_fall = req_prev & ~req_s;

endmodule

// File: rtl/rrhs_fsm.sv
module rrhs_fsm
  import rrhs_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] DEV_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic          wr_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  input  logic          req_fall,
  input  logic          store_busy,
  input  logic          q_full,
  output logic          ready,
  output logic          err,
  output logic          push,
  output logic [DW-1:0] push_data
);

  hs_state_t state_q, state_d;
  logic      err_d;
  logic      hold_en;
  logic      hit;
  logic      room;
  logic [DW-1:0] hold_q;

  // Address is looked at only while the request is sampled high
  assign hit  = req_s && (addr_s == DEV_ADDR);
  assign room = !q_full && !store_busy;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    hold_en = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (hit && !wr_s) begin
          err_d   = 1'b1;
          state_d = HS_REFSE;
        end else if (hit && room) begin
          state_d = HS_GRANT;
        end
      end
      HS_GRANT: begin
        if (req_fall) begin
          hold_en = 1'b1;
          state_d = HS_STORE;
        end
      end
      HS_STORE: begin
        state_d = HS_IDLE;
      end
      HS_REFSE: begin
        if (!req_s) begin
          state_d = HS_IDLE;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  // State and pulse registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      err     <= err_d;
    end
  end

  // Byte holding register, loaded with an explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= data_s;
    end
  end

  assign ready     = (state_q == HS_GRANT) || (state_q == HS_STORE);
  assign push      = (state_q == HS_STORE);
  assign push_data = hold_q;

endmodule

// File: rtl/rrhs_fifo.sv
module rrhs_fifo
  import rrhs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PW = ptr_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] cnt_d;
  logic          do_wr, do_rd;

  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = count;
    if (do_wr) begin
      wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end
    if (do_rd) begin
      rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
    if (do_wr && !do_rd) begin
      cnt_d = count + 1'b1;
    end else if (do_rd && !do_wr) begin
      cnt_d = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= cnt_d;
    end
  end

  // Storage array: no reset, written only through the enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_wr && (wr_ptr == PW'(i))) begin
        mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_ptr];
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);

endmodule

// File: rtl/rrhs_slave.sv
module rrhs_slave
  import rrhs_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] DEV_ADDR = 16'hF800,
  parameter int            DEPTH    = 8   // at least 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          store_busy,
  output logic          ready,
  output logic          err,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          req_s, wr_s, req_fall;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  logic          push;
  logic [DW-1:0] push_data;
  logic          q_full, q_empty;
  logic [CW-1:0] q_count;
  logic          pop_en;

  rrhs_sampler #(.AW(AW), .DW(DW)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .wr       (wr),
    .addr     (addr),
    .data     (data),
    .req_s    (req_s),
    .wr_s     (wr_s),
    .addr_s   (addr_s),
    .data_s   (data_s),
    .req_fall (req_fall)
  );

  rrhs_fsm #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s      (req_s),
    .wr_s       (wr_s),
    .addr_s     (addr_s),
    .data_s     (data_s),
    .req_fall   (req_fall),
    .store_busy (store_busy),
    .q_full     (q_full),
    .ready      (ready),
    .err        (err),
    .push       (push),
    .push_data  (push_data)
  );

  assign pop_en = pop && !q_empty;

  rrhs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push),
    .wr_data (push_data),
    .rd_en   (pop_en),
    .rd_data (pop_data),
    .full    (q_full),
    .empty   (q_empty),
    .count   (q_count)
  );

  assign pop_valid = !q_empty;

endmodule

// File: rtl/rrhs_checker.sv
module rrhs_checker #(
  parameter int            AW       = 16,
  parameter int            DEPTH    = 8,
  parameter logic [AW-1:0] DEV_ADDR = '0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       store_busy,
  input logic                       ready,
  input logic                       err,
  input logic                       pop_valid,
  input logic                       req_s,
  input logic                       wr_s,
  input logic [AW-1:0]              addr_s,
  input logic                       req_fall,
  input logic                       push,
  input logic                       q_full,
  input logic                       pop_en,
  input logic [$clog2(DEPTH+1)-1:0] q_count
);

  AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(req_s && wr_s && (addr_s == DEV_ADDR))); // R2

  AST_NO_BUSY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(!store_busy)); // R8

  AST_NO_FULL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(!q_full)); // R7

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |=> ready); // R4

  AST_RELEASE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_fall) |=> ready ##1 !ready); // R6

  AST_PUSH_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(ready && req_fall)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == ($clog2(DEPTH+1))'(DEPTH)) |-> !(push && !pop_en)); // R7

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R9

  AST_ERR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !ready); // R9

  AST_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop_en) |=> $stable(q_count)); // R10

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid == (q_count != '0)); // R10

endmodule

bind rrhs_slave rrhs_checker #(
  .AW       (AW),
  .DEPTH    (DEPTH),
  .DEV_ADDR (DEV_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .store_busy (store_busy),
  .ready      (ready),
  .err        (err),
  .pop_valid  (pop_valid),
  .req_s      (req_s),
  .wr_s       (wr_s),
  .addr_s     (addr_s),
  .req_fall   (req_fall),
  .push       (push),
  .q_full     (q_full),
  .pop_en     (pop_en),
  .q_count    (q_count)
);

// File: tb/sim_rrhs_slave.sv
module sim_rrhs_slave;

  localparam int          AW    = 16;
  localparam int          DW    = 8;
  localparam logic [15:0] DEV   = 16'hF800;
  localparam int          DEPTH = 8;

  logic          clk;
  logic          rst_n;
  logic          req, wr, store_busy, pop;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          ready, err, pop_valid;
  logic [DW-1:0] pop_data;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  logic drain_en;
  logic [DW-1:0] exp_q [$];

  rrhs_slave #(.AW(AW), .DW(DW), .DEV_ADDR(DEV), .DEPTH(DEPTH)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .wr         (wr),
    .addr       (addr),
    .data       (data),
    .store_busy (store_busy),
    .ready      (ready),
    .err        (err),
    .pop        (pop),
    .pop_data   (pop_data),
    .pop_valid  (pop_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++;
      fails++;
      $display("FAIL watchdog R2 handshake stalled actual=%0d expected<%0d", cyc, 100000);
      summary();
    end
  end

  // Monitor: pops bytes and compares with the scoreboard queue (R5, R10)
  always @(negedge clk) begin
    if (rst_n && drain_en && pop_valid) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected byte", {24'h0, pop_data}, 32'hFFFF_FFFF);
      end else begin
        chk("R5/R10 popped byte", {24'h0, pop_data}, {24'h0, exp_q[0]});
        void'(exp_q.pop_front());
      end
      pop = 1'b1;
    end else begin
      pop = 1'b0;
    end
  end

  // Driver: one write handshake; returns negedges waited for ready
  task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                          input int max_wait, output int waited);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = a;
    waited = 0;
    @(negedge clk);
    chk("R2 ready not before second edge", {31'h0, ready}, 32'h0);
    while (!ready && waited < max_wait) begin
      @(negedge clk);
      waited++;
    end
    if (!ready) begin
      chk("R2 grant", 32'h0, 32'h1);
      req = 1'b0;
    end else begin
      data = d; req = 1'b0;
      exp_q.push_back(d);
      @(negedge clk);
      chk("R4 ready held after req drop", {31'h0, ready}, 32'h1);
      data = ~d; addr = 16'h1234;
      @(negedge clk);
      chk("R6 ready held while storing", {31'h0, ready}, 32'h1);
      @(negedge clk);
      chk("R6 ready released", {31'h0, ready}, 32'h0);
    end
  endtask

  task automatic wait_drained();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int w;
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; data = '0;
    store_busy = 1'b0; drain_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'h0, ready}, 32'h0);
    chk("R1 err in reset", {31'h0, err}, 32'h0);
    chk("R1 pop_valid in reset", {31'h0, pop_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready after reset", {31'h0, ready}, 32'h0);
    chk("R1 pop_valid after reset", {31'h0, pop_valid}, 32'h0);

    // R2 minimal latency, R5 capture, R10 drain
    drain_en = 1'b1;
    do_write(DEV, 8'h3C, 20, w);
    chk("R2 grant latency", w, 1);
    do_write(DEV, 8'hC3, 20, w);
    do_write(DEV, 8'h00, 20, w);
    do_write(DEV, 8'hFF, 20, w);
    wait_drained();
    chk("R5 scoreboard empty", exp_q.size(), 0);

    // R3 mismatching address
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = DEV ^ 16'h0001;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R3 no ready on other address", {31'h0, ready}, 32'h0);
    end
    req = 1'b0;
    // R3 matching address with req low
    addr = DEV;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R3 no ready with req low", {31'h0, ready}, 32'h0);
    end
    chk("R3 nothing stored", {31'h0, pop_valid}, 32'h0);

    // R9 read request refused
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = DEV;
    @(negedge clk);
    chk("R9 err not yet", {31'h0, err}, 32'h0);
    @(negedge clk);
    chk("R9 err pulse", {31'h0, err}, 32'h1);
    chk("R9 no ready", {31'h0, ready}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 err single cycle", {31'h0, err}, 32'h0);
      chk("R9 no ready while held", {31'h0, ready}, 32'h0);
    end
    req = 1'b0; wr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 nothing stored", {31'h0, pop_valid}, 32'h0);

    // R8 storage busy
    store_busy = 1'b1;
    fork
      do_write(DEV, 8'h5A, 40, w);
      begin
        repeat (10) @(negedge clk);
        chk("R8 no ready while busy", {31'h0, ready}, 32'h0);
        store_busy = 1'b0;
      end
    join
    chk("R8 waited for busy", {31'h0, (w >= 9)}, 32'h1);
    wait_drained();

    // R7 full queue
    drain_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) do_write(DEV, 8'h10 + 8'(i), 20, w);
    chk("R10 valid when filled", {31'h0, pop_valid}, 32'h1);
    chk("R10 oldest byte shown", {24'h0, pop_data}, 32'h10);
    fork
      do_write(DEV, 8'hA5, 60, w);
      begin
        repeat (12) @(negedge clk);
        chk("R7 no ready while full", {31'h0, ready}, 32'h0);
        drain_en = 1'b1;
      end
    join
    chk("R7 waited for room", {31'h0, (w >= 11)}, 32'h1);
    wait_drained();
    chk("R7 all bytes delivered", exp_q.size(), 0);
    chk("R10 empty at end", {31'h0, pop_valid}, 32'h0);

    summary();
  end

endmodule